// File: doc/BRIEF.md
# Barrel-Threaded Dual-Issue Scheduler

This block is the issue stage of one throughput-oriented SIMD core. It holds a two-entry window of decoded instructions for each of up to `NTHR` resident hardware threads. Every cycle it selects one thread whose oldest instruction can go, in rotating order. It then sends that instruction, and when the rules allow also the one behind it, to one of four execution-unit classes: vector ALU, special-function unit, load/store unit and branch unit. It never issues for more than one thread in a cycle.

The stage keeps an occupancy counter for the issue port of each unit class and a per-thread register scoreboard. ALU and special-function results clear their scoreboard bits after a fixed latency. Load results clear theirs only on a completion pulse from outside. A thread stalls on a pending load only when an instruction reads or rewrites that register. The front end owns the window. It removes the entries reported as issued: the slot-0 entry of `iss_tid` whenever `iss_vld` is high, and the slot-1 entry as well when `iss_pair` is high.

Top module: `barrel_issue`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, `iss_vld` and `iss_unit` are zero. On the first cycle after reset, `unit_busy` and `sb_pend` are all zero, and the last-issued thread pointer is 0, so thread 1 is the first one searched.
- R2: A thread is ready when its slot 0 is valid and not blocked. Among ready threads, the first one in circular order after the thread that issued most recently is granted, and `iss_tid` names it. Threads that are not ready are passed over.
- R3: Window entry of thread t, slot s, sits at flat index 2t+s in `win_vld` and at bits [(2t+s)*IW +: IW] of `win_ins`, with IW = 3+3*RW and RW = log2(NREG). Fields from LSB upward are: first source (RW bits), second source (RW bits), destination (RW bits), unit code (2 bits: 0 ALU, 1 special-function, 2 load/store, 3 branch) and a subtype bit at the MSB. Bit u of `iss_unit` is the strobe for unit code u.
- R4: Slot 1 issues in the same cycle as slot 0 only if all of the following hold. It targets a different unit class. Its unit is idle. Its own registers are not pending. It neither reads nor rewrites a register that slot 0 writes. `iss_pair` flags such a cycle, and exactly two strobes are then high; otherwise exactly one is.
- R5: If slot 0 of a thread cannot issue, nothing of that thread issues, even when slot 1 could.
- R6: An issue occupies its unit's issue port as follows: load/store 4 cycles, ALU with subtype 1 (fp64) 16 cycles, ALU with subtype 0 (fp32/int32 fused multiply-add) 1 cycle, special-function 2 cycles, branch 1 cycle. `unit_busy[u]` is high while the port is occupied, and no strobe goes to a busy unit.
- R7: A reader of an ALU subtype 0 result may issue 6 cycles after the producer. For an ALU subtype 1 result the wait is 18 cycles, and for a special-function result it is 8 cycles.
- R8: A load (unit 2, subtype 0) marks its destination pending until completion, and the loading thread keeps issuing independent instructions. A store (unit 2, subtype 1) and a branch mark nothing.
- R9: A completion pulse (`cmp_vld` with `cmp_tid`, `cmp_reg`) clears that scoreboard bit. A waiting reader can issue in the next cycle.
- R10: An instruction whose destination is still pending is held, just as one whose source is pending. Both source fields are always checked. The destination is checked for ALU, special-function and load instructions.
- R11: `sb_pend` bit t*NREG+r reflects register r of thread t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_vld | input | 2*NTHR | Valid bit per window entry |
| win_ins | input | 2*NTHR*IW | Decoded window entries |
| cmp_vld | input | 1 | Load completion pulse |
| cmp_tid | input | log2(NTHR) | Thread of the completed load |
| cmp_reg | input | RW | Register of the completed load |
| iss_vld | output | 1 | An instruction issues this cycle |
| iss_pair | output | 1 | Slot 1 issues alongside slot 0 |
| iss_tid | output | log2(NTHR) | Thread that issues |
| iss_unit | output | 4 | Issue strobe per unit class |
| unit_busy | output | 4 | Issue port occupied, per unit class |
| sb_pend | output | NTHR*NREG | Pending-register scoreboard |

## Verification
The pairing rule is swept over every combination of unit classes in the two slots, with independent registers. This separates the one-strobe case from the two-strobe case and shows that strobe positions follow the unit code. Occupancy and latency are measured by counting cycles until a follow-up instruction leaves, for every subtype. The follow-up comes from another thread when port occupancy is measured and from the same thread with a data dependency when result latency is measured, so the two timers are told apart. Directed patterns cover intra-pair dependencies, a blocked slot 0 with a free slot 1, a load that stalls only its readers and writers until its completion pulse, and rotation that passes over a stalled thread.

// File: rtl/barrel_issue_pkg.sv
package barrel_issue_pkg;

    typedef enum logic [1:0] {
        U_VALU = 2'd0,
        U_SFU  = 2'd1,
        U_LSU  = 2'd2,
        U_BRU  = 2'd3
    } unit_e;

    localparam int NUNIT     = 4;
    localparam int OCC_F64_D = 16;
    localparam int OCC_LSU_D = 4;
    localparam int OCC_SFU_D = 2;
    localparam int LAT_FMA_D = 6;
    localparam int LAT_F64_D = 18;
    localparam int LAT_SFU_D = 8;

    // instruction produces a register result
    function automatic logic writes_reg(unit_e u, logic sub);
        return (u == U_VALU) || (u == U_SFU) || (u == U_LSU && !sub);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/barrel_issue_busy.sv
module barrel_issue_busy #(
    parameter int NU = 4,
    parameter int CW = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NU-1:0]          fire,
    input  logic [NU-1:0][CW-1:0]  occ,
    output logic [NU-1:0]          busy
);
    for (genvar u = 0; u < NU; u++) begin : g_unit
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)
                cnt <= '0;
            else if (fire[u])
                cnt <= occ[u] - CW'(1);
            else if (cnt != '0)
                cnt <= cnt - CW'(1);
        end
        assign busy[u] = (cnt != '0);
    end
endmodule

// File: rtl/barrel_issue_dline.sv
// Timed release line: an entry written at position p leaves after p+1 edges.
module barrel_issue_dline #(
    parameter int DEPTH = 5,
    parameter int PW    = 3,
    parameter int TW    = 5,
    parameter int RW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ins,
    input  logic [PW-1:0] pos,
    input  logic [TW-1:0] tid,
    input  logic [RW-1:0] rg,
    output logic          out_v,
    output logic [TW-1:0] out_tid,
    output logic [RW-1:0] out_rg
);
    logic [DEPTH-1:0] v;
    logic [TW-1:0]    tq [DEPTH];
    logic [RW-1:0]    rq [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic put;
        assign put = ins && (pos == PW'(i));
        if (i == DEPTH - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst) v[i] <= 1'b0;
                else     v[i] <= put;
                if (put) begin
                    tq[i] <= tid;
                    rq[i] <= rg;
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst) v[i] <= 1'b0;
                else     v[i] <= put ? 1'b1 : v[i+1];
                tq[i] <= put ? tid : tq[i+1];
                rq[i] <= put ? rg  : rq[i+1];
            end
        end
    end

    assign out_v   = v[0];
    assign out_tid = tq[0];
    assign out_rg  = rq[0];
endmodule

// File: rtl/barrel_issue_sb.sv
module barrel_issue_sb #(
    parameter int NTHR = 32,
    parameter int NREG = 16,
    parameter int TW   = 5,
    parameter int RW   = 4,
    parameter int DA   = 17,
    parameter int PA   = 5,
    parameter int DS   = 7,
    parameter int PS   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               set_v,
    input  logic [1:0][TW-1:0]       set_t,
    input  logic [1:0][RW-1:0]       set_r,
    input  logic                     alu_ins,
    input  logic [PA-1:0]            alu_pos,
    input  logic [TW-1:0]            alu_t,
    input  logic [RW-1:0]            alu_r,
    input  logic                     sfu_ins,
    input  logic [PS-1:0]            sfu_pos,
    input  logic [TW-1:0]            sfu_t,
    input  logic [RW-1:0]            sfu_r,
    input  logic                     cmp_v,
    input  logic [TW-1:0]            cmp_t,
    input  logic [RW-1:0]            cmp_r,
    output logic [NTHR*NREG-1:0]     pend
);
    logic          ae_v, se_v;
    logic [TW-1:0] ae_t, se_t;
    logic [RW-1:0] ae_r, se_r;

    barrel_issue_dline #(.DEPTH(DA), .PW(PA), .TW(TW), .RW(RW)) u_alu_line (
        .clk(clk), .rst(rst), .ins(alu_ins), .pos(alu_pos), .tid(alu_t), .rg(alu_r),
        .out_v(ae_v), .out_tid(ae_t), .out_rg(ae_r)
    );

    barrel_issue_dline #(.DEPTH(DS), .PW(PS), .TW(TW), .RW(RW)) u_sfu_line (
        .clk(clk), .rst(rst), .ins(sfu_ins), .pos(sfu_pos), .tid(sfu_t), .rg(sfu_r),
        .out_v(se_v), .out_tid(se_t), .out_rg(se_r)
    );

    logic [NTHR*NREG-1:0] setm, clrm;

    always_comb begin
        setm = '0;
        clrm = '0;
        for (int k = 0; k < 2; k++)
            if (set_v[k]) setm[int'(set_t[k])*NREG + int'(set_r[k])] = 1'b1;
        if (ae_v)  clrm[int'(ae_t)*NREG + int'(ae_r)]   = 1'b1;
        if (se_v)  clrm[int'(se_t)*NREG + int'(se_r)]   = 1'b1;
        if (cmp_v) clrm[int'(cmp_t)*NREG + int'(cmp_r)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clrm) | setm;
    end
endmodule

// File: rtl/barrel_issue_rr.sv
module barrel_issue_rr #(
    parameter int N  = 32,
    parameter int TW = 5
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] last,
    output logic          gv,
    output logic [TW-1:0] g
);
    always_comb begin
        gv = 1'b0;
        g  = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (!gv && req[idx]) begin
                gv = 1'b1;
                g  = TW'(idx);
            end
        end
    end
endmodule

// File: rtl/barrel_issue.sv
module barrel_issue
    import barrel_issue_pkg::*;
#(
    parameter int NTHR    = 32,
    parameter int NREG    = 16,
    parameter int OCC_F64 = OCC_F64_D,
    parameter int OCC_LSU = OCC_LSU_D,
    parameter int OCC_SFU = OCC_SFU_D,
    parameter int LAT_FMA = LAT_FMA_D,
    parameter int LAT_F64 = LAT_F64_D,
    parameter int LAT_SFU = LAT_SFU_D
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [2*NTHR-1:0]                         win_vld,
    input  logic [2*NTHR*(3+3*$clog2(NREG))-1:0]      win_ins,
    input  logic                                      cmp_vld,
    input  logic [$clog2(NTHR)-1:0]                   cmp_tid,
    input  logic [$clog2(NREG)-1:0]                   cmp_reg,
    output logic                                      iss_vld,
    output logic                                      iss_pair,
    output logic [$clog2(NTHR)-1:0]                   iss_tid,
    output logic [3:0]                                iss_unit,
    output logic [3:0]                                unit_busy,
    output logic [NTHR*NREG-1:0]                      sb_pend
);
    localparam int TW   = $clog2(NTHR);
    localparam int RW   = $clog2(NREG);
    localparam int IW   = 3 + 3*RW;
    localparam int OMAX = imax(imax(OCC_F64, OCC_LSU), OCC_SFU);
    localparam int CW   = $clog2(OMAX + 1);
    localparam int DA   = LAT_F64 - 1;
    localparam int PA   = $clog2(DA);
    localparam int DS   = LAT_SFU - 1;
    localparam int PS   = $clog2(DS);

    typedef struct packed {
        logic          sub;
        unit_e         unit;
        logic [RW-1:0] dst;
        logic [RW-1:0] s1;
        logic [RW-1:0] s0;
    } insn_t;

    insn_t           ins0 [NTHR];
    insn_t           ins1 [NTHR];
    logic [NTHR-1:0] v0, v1, ready;

    for (genvar t = 0; t < NTHR; t++) begin : g_win
        assign ins0[t] = insn_t'(win_ins[(2*t)*IW   +: IW]);
        assign ins1[t] = insn_t'(win_ins[(2*t+1)*IW +: IW]);
        assign v0[t]   = win_vld[2*t];
        assign v1[t]   = win_vld[2*t+1];
    end

    function automatic logic blocked(insn_t i, int t, logic [NTHR*NREG-1:0] pv, logic [3:0] bz);
        int b;
        b = t * NREG;
        return bz[i.unit] || pv[b + int'(i.s0)] || pv[b + int'(i.s1)]
            || (writes_reg(i.unit, i.sub) && pv[b + int'(i.dst)]);
    endfunction

    function automatic logic [CW-1:0] occ_of(insn_t i);
        case (i.unit)
            U_VALU:  return i.sub ? CW'(OCC_F64) : CW'(1);
            U_SFU:   return CW'(OCC_SFU);
            U_LSU:   return CW'(OCC_LSU);
            default: return CW'(1);
        endcase
    endfunction

    always_comb
        for (int t = 0; t < NTHR; t++)
            ready[t] = v0[t] && !blocked(ins0[t], t, sb_pend, unit_busy);

    // round-robin pick
    logic          gv;
    logic [TW-1:0] gnt, last_q;

    barrel_issue_rr #(.N(NTHR), .TW(TW)) u_rr (
        .req(ready), .last(last_q), .gv(gv), .g(gnt)
    );

    always_ff @(posedge clk) begin
        if (rst)     last_q <= '0;
        else if (gv) last_q <= gnt;
    end

    // pairing of the selected thread
    insn_t sel0, sel1;
    logic  sv1, dep, go, two;

    assign sel0 = ins0[gnt];
    assign sel1 = ins1[gnt];
    assign sv1  = v1[gnt];
    assign dep  = writes_reg(sel0.unit, sel0.sub) &&
                  (sel1.s0 == sel0.dst || sel1.s1 == sel0.dst ||
                   (writes_reg(sel1.unit, sel1.sub) && sel1.dst == sel0.dst));
    assign go   = gv && !rst;
    assign two  = go && sv1 && (sel1.unit != sel0.unit) && !dep &&
                  !blocked(sel1, int'(gnt), sb_pend, unit_busy);

    assign iss_vld  = go;
    assign iss_pair = two;
    assign iss_tid  = gnt;
    assign iss_unit = go ? ((4'b0001 << sel0.unit) | (two ? (4'b0001 << sel1.unit) : 4'b0000))
                         : 4'b0000;

    // port occupancy
    logic [3:0][CW-1:0] occ_req;
    always_comb begin
        occ_req = '0;
        occ_req[sel0.unit] = occ_of(sel0);
        if (two) occ_req[sel1.unit] = occ_of(sel1);
    end

    barrel_issue_busy #(.NU(NUNIT), .CW(CW)) u_busy (
        .clk(clk), .rst(rst), .fire(iss_unit), .occ(occ_req), .busy(unit_busy)
    );

    // scoreboard updates
    logic  alu1, sfu1, alu_ins, sfu_ins;
    insn_t alu_src, sfu_src;

    assign alu1    = two && sel1.unit == U_VALU;
    assign sfu1    = two && sel1.unit == U_SFU;
    assign alu_src = alu1 ? sel1 : sel0;
    assign sfu_src = sfu1 ? sel1 : sel0;
    assign alu_ins = (go && sel0.unit == U_VALU) || alu1;
    assign sfu_ins = (go && sel0.unit == U_SFU)  || sfu1;

    barrel_issue_sb #(
        .NTHR(NTHR), .NREG(NREG), .TW(TW), .RW(RW),
        .DA(DA), .PA(PA), .DS(DS), .PS(PS)
    ) u_sb (
        .clk(clk), .rst(rst),
        .set_v({two && writes_reg(sel1.unit, sel1.sub), go && writes_reg(sel0.unit, sel0.sub)}),
        .set_t({gnt, gnt}),
        .set_r({sel1.dst, sel0.dst}),
        .alu_ins(alu_ins),
        .alu_pos(alu_src.sub ? PA'(LAT_F64 - 2) : PA'(LAT_FMA - 2)),
        .alu_t(gnt), .alu_r(alu_src.dst),
        .sfu_ins(sfu_ins), .sfu_pos(PS'(LAT_SFU - 2)),
        .sfu_t(gnt), .sfu_r(sfu_src.dst),
        .cmp_v(cmp_vld), .cmp_t(cmp_tid), .cmp_r(cmp_reg),
        .pend(sb_pend)
    );
endmodule

// File: rtl/barrel_issue_chk.sv
module barrel_issue_chk #(
    parameter int NTHR    = 32,
    parameter int NREG    = 16,
    parameter int OCC_LSU = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       iss_vld,
    input logic                       iss_pair,
    input logic [3:0]                 iss_unit,
    input logic [3:0]                 unit_busy,
    input logic [NTHR*NREG-1:0]       sb_pend,
    input logic                       cmp_vld,
    input logic [$clog2(NTHR)-1:0]    cmp_tid,
    input logic [$clog2(NREG)-1:0]    cmp_reg
);
    int cidx;
    always_comb cidx = int'(cmp_tid) * NREG + int'(cmp_reg);

    always @(posedge clk)
        if (rst)
            p_quiet_in_reset_r1: assert (iss_unit == 4'b0000 && !iss_vld)
                else $error("strobe during reset");

    p_clean_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (unit_busy == 4'b0000 && sb_pend == '0));

    p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && !iss_pair) |-> $countones(iss_unit) == 1);

    p_pair_strobes_r4: assert property (@(posedge clk) disable iff (rst)
        iss_pair |-> $countones(iss_unit) == 2);

    p_pair_needs_head_r5: assert property (@(posedge clk) disable iff (rst)
        iss_pair |-> iss_vld);

    for (genvar u = 0; u < 4; u++) begin : g_port
        p_no_issue_to_busy_r6: assert property (@(posedge clk) disable iff (rst)
            unit_busy[u] |-> !iss_unit[u]);
    end

    if (OCC_LSU > 1) begin : g_lsu
        p_lsu_held_r6: assert property (@(posedge clk) disable iff (rst)
            iss_unit[2] |=> unit_busy[2]);
    end

    p_completion_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (cmp_vld && sb_pend[cidx]) |=> !sb_pend[$past(cidx)]);
endmodule

bind barrel_issue barrel_issue_chk #(.NTHR(NTHR), .NREG(NREG), .OCC_LSU(OCC_LSU)) u_chk (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_pair(iss_pair), .iss_unit(iss_unit),
    .unit_busy(unit_busy), .sb_pend(sb_pend), .cmp_vld(cmp_vld), .cmp_tid(cmp_tid),
    .cmp_reg(cmp_reg)
);

// File: tb/tb_barrel_issue.sv
`timescale 1ns/1ps
module tb_barrel_issue;
    localparam int NT = 4;
    localparam int NR = 8;
    localparam int IW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [2*NT-1:0]    vld;
    logic [2*NT*IW-1:0] ins;
    logic          cmp_v;
    logic [1:0]    cmp_t;
    logic [2:0]    cmp_r;
    logic          iss_vld, iss_pair;
    logic [1:0]    iss_tid;
    logic [3:0]    iss_unit, unit_busy;
    logic [NT*NR-1:0] sb_pend;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    barrel_issue #(.NTHR(NT), .NREG(NR)) dut (
        .clk(clk), .rst(rst), .win_vld(vld), .win_ins(ins),
        .cmp_vld(cmp_v), .cmp_tid(cmp_t), .cmp_reg(cmp_r),
        .iss_vld(iss_vld), .iss_pair(iss_pair), .iss_tid(iss_tid),
        .iss_unit(iss_unit), .unit_busy(unit_busy), .sb_pend(sb_pend)
    );

    function automatic logic [IW-1:0] mk(int u, int sub, int d, int s1, int s0);
        return {1'(sub), 2'(u), 3'(d), 3'(s1), 3'(s0)};
    endfunction

    task automatic put(int t, int s, logic [IW-1:0] w);
        ins[(2*t+s)*IW +: IW] = w;
        vld[2*t+s] = 1'b1;
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic adv();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic drain(int n);
        vld = '0;
        repeat (n) adv();
    endtask

    task automatic complete(int t, int r);
        cmp_v = 1'b1; cmp_t = 2'(t); cmp_r = 3'(r);
        adv();
        cmp_v = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int order [4];
        int occs [6];
        int us [6];
        int subs [6];
        int lat_u [3];
        int lat_s [3];
        int lats [3];
        rst = 1'b1; vld = '0; ins = '0; cmp_v = 1'b0; cmp_t = '0; cmp_r = '0;

        // R1 reset quiet with a ready thread
        put(0, 0, mk(0, 0, 1, 2, 3));
        adv(); settle();
        chk("R1 no issue in reset", int'(iss_vld), 0);
        chk("R1 no strobe in reset", int'(iss_unit), 0);
        adv();
        rst = 1'b0; vld = '0;
        settle();
        chk("R1 busy clear", int'(unit_busy), 0);
        chk("R1 scoreboard clear", int'(sb_pend != '0), 0);

        // R2 rotation from pointer 0: 1,2,3,0
        for (int t = 0; t < NT; t++) put(t, 0, mk(0, 0, 1, 2, 3));
        order = '{1, 2, 3, 0};
        for (int k = 0; k < 4; k++) begin
            settle();
            chk("R2 rotation tid", iss_vld ? int'(iss_tid) : -1, order[k]);
            chk("R3 alu strobe", int'(iss_unit), 1);
            adv();
            vld[2*order[k]] = 1'b0;
        end
        drain(24);

        // R2 skip stalled thread; R8 reader waits on load; R9 completion
        put(1, 0, mk(2, 0, 2, 0, 0));
        settle();
        chk("R8 load issues", iss_vld ? int'(iss_tid) : -1, 1);
        adv(); vld = '0;
        put(1, 0, mk(0, 0, 3, 4, 2));
        put(0, 0, mk(0, 0, 1, 5, 6));
        put(2, 0, mk(0, 0, 1, 5, 6));
        put(3, 0, mk(0, 0, 1, 5, 6));
        order = '{2, 3, 0, 0};
        for (int k = 0; k < 3; k++) begin
            settle();
            chk("R2 skip stalled thread", iss_vld ? int'(iss_tid) : -1, order[k]);
            adv();
            vld[2*order[k]] = 1'b0;
        end
        settle();
        chk("R8 reader of pending load held", int'(iss_vld), 0);
        chk("R11 load bit index", int'(sb_pend[1*NR+2]), 1);
        cmp_v = 1'b1; cmp_t = 2'd1; cmp_r = 3'd2;
        settle();
        chk("R9 not released same cycle", int'(iss_vld), 0);
        adv(); cmp_v = 1'b0;
        settle();
        chk("R9 released next cycle", iss_vld ? int'(iss_tid) : -1, 1);
        drain(24);

        // R3/R4 sweep of unit pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                int exp_u;
                put(0, 0, mk(a, 0, 1, 2, 3));
                put(0, 1, mk(b, 0, 4, 5, 6));
                settle();
                exp_u = (1 << a) | ((a != b) ? (1 << b) : 0);
                chk("R3 strobe map", int'(iss_unit), exp_u);
                chk("R4 pair flag", int'(iss_pair), int'(a != b));
                adv();
                vld = '0;
                if (a == 2) complete(0, 1);
                if (b == 2 && a != b) complete(0, 4);
                drain(20);
            end
        end

        // R4 intra-pair dependencies
        put(0, 0, mk(0, 0, 4, 1, 2));
        put(0, 1, mk(1, 0, 5, 0, 4));
        settle();
        chk("R4 read-after-write pair split", int'(iss_unit), 1);
        adv(); drain(20);
        put(0, 0, mk(0, 0, 4, 1, 2));
        put(0, 1, mk(2, 0, 4, 5, 6));
        settle();
        chk("R4 same destination pair split", int'(iss_pair), 0);
        adv(); drain(20);

        // R5 / R10 / R8 with a pending load on r7 of thread 0
        put(0, 0, mk(2, 0, 7, 0, 0));
        settle();
        adv(); vld = '0;
        put(0, 0, mk(0, 0, 3, 7, 1));
        put(0, 1, mk(1, 0, 5, 4, 6));
        settle();
        chk("R5 blocked head holds slot 1", int'(iss_vld), 0);
        adv(); vld = '0;
        put(0, 0, mk(0, 0, 7, 1, 2));
        settle();
        chk("R10 pending destination held", int'(iss_vld), 0);
        adv(); vld = '0;
        put(0, 0, mk(0, 0, 3, 1, 2));
        settle();
        chk("R8 independent issue under load", int'(iss_vld), 1);
        adv(); vld = '0;
        complete(0, 7);
        drain(24);

        // R6 occupancy sweep: second thread waits for the port
        us    = '{0, 0, 1, 2, 2, 3};
        subs  = '{0, 1, 0, 0, 1, 0};
        occs  = '{1, 16, 2, 4, 4, 1};
        for (int k = 0; k < 6; k++) begin
            int n;
            put(0, 0, mk(us[k], subs[k], 1, 2, 3));
            settle();
            chk("R6 first issue", int'(iss_unit), 1 << us[k]);
            adv(); vld = '0;
            put(1, 0, mk(us[k], subs[k], 1, 2, 3));
            settle();
            chk("R6 busy flag", int'(unit_busy[us[k]]), int'(occs[k] > 1));
            if (us[k] == 2 && subs[k] == 1)
                chk("R8 store marks nothing", int'(sb_pend != '0), 0);
            n = 1;
            while (!iss_vld && n < 40) begin
                adv(); settle();
                n++;
            end
            chk("R6 occupancy cycles", n, occs[k]);
            adv(); vld = '0;
            if (us[k] == 2 && subs[k] == 0) begin
                complete(0, 1);
                complete(1, 1);
            end
            drain(24);
        end

        // R7 result latency: dependent of the same thread
        lat_u = '{0, 0, 1};
        lat_s = '{0, 1, 0};
        lats  = '{6, 18, 8};
        for (int k = 0; k < 3; k++) begin
            int n;
            put(2, 0, mk(lat_u[k], lat_s[k], 5, 0, 1));
            settle();
            adv(); vld = '0;
            put(2, 0, mk(lat_u[k], lat_s[k], 6, 5, 0));
            settle();
            chk("R11 result bit index", int'(sb_pend[2*NR+5]), 1);
            n = 1;
            while (!iss_vld && n < 40) begin
                adv(); settle();
                n++;
            end
            chk("R7 result latency", n, lats[k]);
            adv();
            drain(24);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule